// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status and Mask Unit

This block collects the interrupt causes of a small Ethernet controller and presents them to host software as one status byte, one mask byte and one acknowledge byte. Transmit completion, transmit-FIFO-empty and receive-overrun arrive as one-cycle pulses and are held until software clears them. Receive-pending and allocation-done are level inputs that the status shows directly. Three protocol-handler exception sources, each with its own enable, are merged into a single exception bit.

Nine PHY status lines are watched. When one changes, its new value is frozen in a snapshot that software can read, and a sticky management-PHY bit is raised. Reading the snapshot reloads it from the live lines. A single registered level output interrupts the host whenever an unmasked status bit is set.

Top module: `ethirq_top`

## Requirements
- R1: After a synchronous reset, the following are all zero: the mask byte, the exception enables, the held status bits, the PHY snapshot and the host interrupt.
- R2: The status byte has this layout. Bit 7 is the PHY change bit. Bit 6 always reads 0. Bit 5 is the exception bit. Bit 4 is receive overrun. Bit 3 is allocation done. Bit 2 is transmit empty. Bit 1 is transmit done. Bit 0 is receive pending.
- R3: The register port uses word addresses. At address 0, bits 7:0 read the status and take acknowledge writes, and bits 15:8 are the read/write mask. At address 1, bits 2:0 are the exception enables: bit 0 is link transition, bit 1 is counter rollover, bit 2 is transmit forced off. At address 2, bits 8:0 read the PHY snapshot. Unused bits read 0.
- R4: Byte enable 0 selects bits 7:0 of a write and byte enable 1 selects bits 15:8. A byte that is not enabled is left unchanged.
- R5: Status bits 1, 2 and 4 set on their input pulse. They clear when 1 is written to the same bit at address 0. Writing 0 leaves them set.
- R6: When an event and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R7: Status bits 0 and 3 follow their level inputs, and acknowledge writes have no effect on them.
- R8: Status bit 5 is the OR of the exception sources ANDed with their enables. Writing 1 to bit 5 of the acknowledge has no effect.
- R9: A change on any unlocked PHY line sets status bit 7. Bit 7 clears only when 1 is written to bit 7 of the acknowledge, and a new change in that same cycle wins.
- R10: A PHY bit that has changed is locked and keeps its captured value until address 2 is read. That read reloads the whole snapshot from the live lines and unlocks every bit.
- R11: The host interrupt equals the OR of status ANDed with mask, taken one clock earlier. A mask bit of 0 blocks its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pend_i | input | 1 | Receive-pending level |
| alloc_done_i | input | 1 | Allocation-done level |
| tx_done_p_i | input | 1 | Transmit-done pulse |
| tx_empty_p_i | input | 1 | Transmit-FIFO-empty pulse |
| rx_ovrn_p_i | input | 1 | Receive-overrun pulse |
| exc_src_i | input | 3 | Exception source levels (link, rollover, transmit off) |
| phy_live_i | input | 9 | Live PHY status lines |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address |
| be_i | input | 2 | Byte enables |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| irq_o | output | 1 | Host interrupt level |

## Verification
A held status bit that fails to set, or fails to clear, shows up at the port as a wrong value at address 0 on the very next read. Because the interrupt output is registered, the same fault reaches it one cycle later. A PHY lock that is lost lets the snapshot follow the live lines, so the next read of address 2 returns the live value in place of the captured one. The checks therefore read back every register right after each stimulus. They also time the interrupt edge to the exact cycle, so that a missing or extra register stage is caught.

// File: rtl/ethirq_pkg.sv
package ethirq_pkg;
    localparam int STAT_W  = 8;
    localparam int PHY_W   = 9;
    localparam int EXC_W   = 3;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 16;
    localparam int HELD_W  = 3;

    localparam int B_RX    = 0;
    localparam int B_TXD   = 1;
    localparam int B_TXE   = 2;
    localparam int B_ALLOC = 3;
    localparam int B_OVRN  = 4;
    localparam int B_EXC   = 5;
    localparam int B_PHY   = 7;

    localparam logic [ADDR_W-1:0] A_IRQ   = 2'd0;
    localparam logic [ADDR_W-1:0] A_EXCEN = 2'd1;
    localparam logic [ADDR_W-1:0] A_PHY   = 2'd2;

    typedef struct packed {
        logic ovrn;
        logic tx_empty;
        logic tx_done;
    } held_t;

    typedef struct packed {
        logic                  rd;
        logic                  wr;
        logic [ADDR_W-1:0]     addr;
        logic [1:0]            be;
        logic [DATA_W-1:0]     wdata;
    } bus_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic  phy_chg,
        input logic  exc_hit,
        input held_t held,
        input logic  alloc,
        input logic  rx
    );
        pack_status = {phy_chg, 1'b0, exc_hit, held.ovrn, alloc,
                       held.tx_empty, held.tx_done, rx};
    endfunction

    function automatic held_t pick_held(input logic [STAT_W-1:0] v);
        pick_held.ovrn     = v[B_OVRN];
        pick_held.tx_empty = v[B_TXE];
        pick_held.tx_done  = v[B_TXD];
    endfunction
endpackage

// File: rtl/ethirq_sticky.sv
module ethirq_sticky #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst)           q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
        end
        assign q_o[i] = q;

        assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q_o[i]);
        assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
        assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);
    end
endmodule

// File: rtl/ethirq_phy_watch.sv
module ethirq_phy_watch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] live_i,
    input  logic         refresh_i,
    input  logic         ack_i,
    output logic [W-1:0] snap_o,
    output logic         chg_o
);
    logic [W-1:0] snap_q;
    logic [W-1:0] lock_q;
    logic [W-1:0] diff;
    logic         chg_q;

    assign diff = (live_i ^ snap_q) & ~lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            lock_q <= '0;
            chg_q  <= 1'b0;
        end else begin
            chg_q <= (|diff) | (chg_q & ~ack_i);
            if (refresh_i) begin
                snap_q <= live_i;
                lock_q <= '0;
            end else begin
                snap_q <= (snap_q & lock_q) | (live_i & ~lock_q);
                lock_q <= lock_q | diff;
            end
        end
    end

    assign snap_o = snap_q;
    assign chg_o  = chg_q;

    assert_locked_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !refresh_i |=> (((snap_o ^ $past(snap_o)) & $past(lock_q)) == '0));
    assert_refresh_live_R10: assert property (@(posedge clk) disable iff (rst)
        refresh_i |=> (snap_o == $past(live_i)));
    assert_clear_by_ack_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(chg_o) |-> $past(ack_i));
endmodule

// File: rtl/ethirq_exc.sv
module ethirq_exc #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] en_o,
    output logic         hit_o
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)       en_q <= '0;
        else if (wr_i) en_q <= wdata_i;
    end

    assign en_o  = en_q;
    assign hit_o = |(src_i & en_q);

    assert_en_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/ethirq_top.sv
module ethirq_top
    import ethirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_pend_i,
    input  logic              alloc_done_i,
    input  logic              tx_done_p_i,
    input  logic              tx_empty_p_i,
    input  logic              rx_ovrn_p_i,
    input  logic [EXC_W-1:0]  exc_src_i,
    input  logic [PHY_W-1:0]  phy_live_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    bus_t              bus;
    logic              ack_lo, mask_wr, exc_wr, phy_rd;
    held_t             held_set, held_clr, held_q;
    logic [STAT_W-1:0] mask_q, status;
    logic [EXC_W-1:0]  exc_en;
    logic              exc_hit, phy_chg;
    logic [PHY_W-1:0]  phy_snap;
    logic              irq_q;

    assign bus = '{rd: rd_en_i, wr: wr_en_i, addr: addr_i, be: be_i, wdata: wdata_i};

    assign ack_lo  = bus.wr && bus.addr == A_IRQ   && bus.be[0];
    assign mask_wr = bus.wr && bus.addr == A_IRQ   && bus.be[1];
    assign exc_wr  = bus.wr && bus.addr == A_EXCEN && bus.be[0];
    assign phy_rd  = bus.rd && bus.addr == A_PHY;

    assign held_set = '{ovrn: rx_ovrn_p_i, tx_empty: tx_empty_p_i, tx_done: tx_done_p_i};
    assign held_clr = ack_lo ? pick_held(bus.wdata[STAT_W-1:0]) : '0;

    ethirq_sticky #(.W(HELD_W)) u_held (
        .clk   (clk),
        .rst   (rst),
        .set_i (held_set),
        .clr_i (held_clr),
        .q_o   (held_q)
    );

    ethirq_exc #(.N(EXC_W)) u_exc (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (exc_wr),
        .wdata_i (bus.wdata[EXC_W-1:0]),
        .src_i   (exc_src_i),
        .en_o    (exc_en),
        .hit_o   (exc_hit)
    );

    ethirq_phy_watch #(.W(PHY_W)) u_phy (
        .clk       (clk),
        .rst       (rst),
        .live_i    (phy_live_i),
        .refresh_i (phy_rd),
        .ack_i     (ack_lo && bus.wdata[B_PHY]),
        .snap_o    (phy_snap),
        .chg_o     (phy_chg)
    );

    assign status = pack_status(phy_chg, exc_hit, held_q, alloc_done_i, rx_pend_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (mask_wr) mask_q <= bus.wdata[DATA_W-1:STAT_W];
            irq_q <= |(status & mask_q);
        end
    end

    always_comb begin
        case (bus.addr)
            A_IRQ:   rdata_o = {mask_q, status};
            A_EXCEN: rdata_o = {{(DATA_W-EXC_W){1'b0}}, exc_en};
            A_PHY:   rdata_o = {{(DATA_W-PHY_W){1'b0}}, phy_snap};
            default: rdata_o = '0;
        endcase
    end

    assign irq_o = irq_q;

    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !irq_o);
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));
    assert_rx_live_R7: assert property (@(posedge clk) disable iff (rst)
        (bus.rd && bus.addr == A_IRQ) |-> (rdata_o[B_RX] == rx_pend_i));
endmodule

// File: tb/test_ethirq_top.sv
module test_ethirq_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        rx_pend, alloc_done, tx_done_p, tx_empty_p, rx_ovrn_p;
    logic [2:0]  exc_src;
    logic [8:0]  phy_live;
    logic        rd_en, wr_en;
    logic [1:0]  addr, be;
    logic [15:0] wdata, rdata;
    logic        irq;

    typedef struct {
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    always #10 clk = ~clk;

    ethirq_top i_ethirq_top (
        .clk(clk), .rst(rst), .rx_pend_i(rx_pend), .alloc_done_i(alloc_done),
        .tx_done_p_i(tx_done_p), .tx_empty_p_i(tx_empty_p), .rx_ovrn_p_i(rx_ovrn_p),
        .exc_src_i(exc_src), .phy_live_i(phy_live), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // monitor: compare read data against the scoreboard at the falling edge
    always @(negedge clk) begin
        if (rd_en && !rst) begin
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL monitor: unexpected read, actual %h expected none", rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: addr %0d actual %h expected %h", it.req, addr, rdata, it.exp);
                end
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] b, input logic [15:0] d);
        wr_en = 1'b1; addr = a; be = b; wdata = d;
        tick;
        wr_en = 1'b0; be = 2'b00; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string r);
        item_t it;
        it.exp = e; it.req = r;
        sb.push_back(it);
        rd_en = 1'b1; addr = a;
        tick;
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string r);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq actual %b expected %b", r, irq, e);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rx_pend = 0; alloc_done = 0; tx_done_p = 0; tx_empty_p = 0;
        rx_ovrn_p = 0; exc_src = '0; phy_live = '0; rd_en = 0; wr_en = 0;
        addr = '0; be = '0; wdata = '0;
        tick; tick; tick;
        rst = 1'b0;
        tick;

        // R1 reset state
        rd(2'd0, 16'h0000, "R1");
        rd(2'd1, 16'h0000, "R1");
        rd(2'd2, 16'h0000, "R1");
        chk_irq(1'b0, "R1");

        // R5 held pulses, R2 bit positions
        tx_done_p = 1; tick; tx_done_p = 0;
        rd(2'd0, 16'h0002, "R5");
        tx_empty_p = 1; rx_ovrn_p = 1; tick; tx_empty_p = 0; rx_ovrn_p = 0;
        rd(2'd0, 16'h0016, "R2");
        wr(2'd0, 2'b01, 16'h0000);
        rd(2'd0, 16'h0016, "R5");
        wr(2'd0, 2'b01, 16'h0002);
        rd(2'd0, 16'h0014, "R5");

        // R4 byte lanes, R3 mask position, R11 interrupt timing
        wr(2'd0, 2'b10, 16'hFF16);
        rd(2'd0, 16'hFF14, "R4");
        chk_irq(1'b1, "R11");
        wr(2'd0, 2'b01, 16'h0014);
        chk_irq(1'b1, "R11");
        tick;
        chk_irq(1'b0, "R11");
        rd(2'd0, 16'hFF00, "R4");

        // R6 set wins over acknowledge
        tx_done_p = 1;
        wr(2'd0, 2'b01, 16'h0002);
        tx_done_p = 0;
        rd(2'd0, 16'hFF02, "R6");
        wr(2'd0, 2'b01, 16'h0002);
        rd(2'd0, 16'hFF00, "R6");

        // R7 live bits
        rx_pend = 1; alloc_done = 1;
        rd(2'd0, 16'hFF09, "R7");
        wr(2'd0, 2'b01, 16'h0009);
        rd(2'd0, 16'hFF09, "R7");
        rx_pend = 0; alloc_done = 0;
        rd(2'd0, 16'hFF00, "R7");

        // R8 exception summary
        exc_src = 3'b001;
        rd(2'd0, 16'hFF00, "R8");
        wr(2'd1, 2'b01, 16'h0001);
        rd(2'd1, 16'h0001, "R3");
        rd(2'd0, 16'hFF20, "R8");
        wr(2'd0, 2'b01, 16'h0020);
        rd(2'd0, 16'hFF20, "R8");
        exc_src = 3'b010;
        rd(2'd0, 16'hFF00, "R8");
        exc_src = 3'b000;

        // R11 zero mask blocks interrupt
        wr(2'd0, 2'b10, 16'h0000);
        tx_done_p = 1; tick; tx_done_p = 0;
        tick;
        chk_irq(1'b0, "R11");
        rd(2'd0, 16'h0002, "R11");
        wr(2'd0, 2'b01, 16'h0002);

        // R9 / R10 PHY change tracking
        phy_live = 9'h001; tick;
        phy_live = 9'h000; tick;
        rd(2'd2, 16'h0001, "R10");
        rd(2'd2, 16'h0000, "R10");
        rd(2'd0, 16'h0080, "R9");
        wr(2'd0, 2'b01, 16'h0000);
        rd(2'd0, 16'h0080, "R9");
        wr(2'd0, 2'b01, 16'h0080);
        rd(2'd0, 16'h0000, "R9");
        phy_live = 9'h100; tick;
        rd(2'd0, 16'h0080, "R9");
        rd(2'd2, 16'h0100, "R10");
        phy_live = 9'h000;
        wr(2'd0, 2'b01, 16'h0080);
        rd(2'd0, 16'h0080, "R9");
        tick;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule